// File: doc/BRIEF.md
# UART Queue Pair with Host Test-Access Mode

This block holds the two byte queues of a UART-style channel: a receive queue, filled by the serial side and emptied by the host, and a transmit queue, filled by the host and emptied by the serial side. The host reaches the block through a small 32-bit register bus. The serial side is a pair of push and pop strobes, so baud timing and framing stay outside the block.

A one-bit test-access control reverses both queues. Host writes to the data register go into the receive queue, host reads of the data register drain the transmit queue, and the serial strobes are ignored. Software can then exercise both queues with no line traffic. Every change of this bit empties both queues one cycle later. A run-time enable selects full queue depth or a single holding entry per direction. Two build-time parameters can remove the queues or the test-access feature.

Top module: `uart_tap_ctrl`

## Requirements
- R1: After reset the test-access bit reads 0, the queue-enable bit reads 0, the status register reads 0x5 (both queues empty) and `ser_tx_valid` is 0.
- R2: The test-access bit is bit 0 of the register at offset 0x70. A write there sets it to write-data bit 0. Bits 31:1 always read 0 and ignore writes. No other access changes the bit.
- R3: With `ACC_EN` = 0, writes to offset 0x70 have no effect, the register still reads (as 0), and the normal data path works.
- R4: In normal mode, bytes pushed on `ser_rx_push` come back in arrival order from host reads of the data register at offset 0x00. Host writes to offset 0x00 reach `ser_tx_data` in write order, and each `ser_tx_pop` advances to the next byte.
- R5: In test-access mode, a host write to offset 0x00 pushes into the receive queue. A host read of offset 0x00 returns and pops the transmit-queue head, not receive-queue data.
- R6: The queue-enable bit (offset 0x08, bit 0) set to 1 gives `DEPTH` entries per queue. Set to 0, each queue holds one entry, in either mode.
- R7: A write that changes the test-access bit leaves both queues as they were for one more cycle, then empties both. Writing the value already held empties nothing.
- R8: In test-access mode, `ser_rx_push` and `ser_tx_pop` are ignored.
- R9: A pop from an empty queue returns 0 and moves nothing. A push into a full queue is dropped, and the stored bytes come out unchanged.
- R10: The status register at offset 0x14 reads bit 0 receive-empty, bit 1 receive-full, bit 2 transmit-empty, bit 3 transmit-full, with all other bits 0.
- R11: With `FIFO_PRESENT` = 0, the queue-enable bit stays 0 whatever is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (pops on data register) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| ser_rx_push | input | 1 | Serial side delivers a received byte |
| ser_rx_data | input | WIDTH | Received byte |
| ser_tx_pop | input | 1 | Serial side consumes the transmit head |
| ser_tx_data | output | WIDTH | Transmit-queue head, 0 when empty |
| ser_tx_valid | output | 1 | Transmit queue not empty |

## Verification
A corrupt queue pointer or count shows up on the next host read of the data register as a wrong or reordered byte. It also shows in the status flags and in `ser_tx_data`/`ser_tx_valid`, which the bench compares with its model on every clock. A stuck or mistimed test-access bit sends host writes into the wrong queue, so the status flags diverge at the first sample after the write. A flush that fires a cycle early, fires a cycle late or never fires is caught by checking `ser_tx_valid` and the status register in the two cycles after the mode write.

// File: rtl/uart_tap_pkg.sv
// Shared register offsets for the UART queue pair with test access.
// Assumes an 8-bit byte-offset register bus with 32-bit data.
package uart_tap_pkg;
    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_TACC = 8'h70;

    // Status flags, packed so that the LSB is receive-empty.
    typedef struct packed {
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
    } tap_status_t;
endpackage

// File: rtl/tap_fifo.sv
// Circular byte queue with a run-time single-entry limit and a pointer flush.
// Assumes: flush overrides push and pop in the same cycle; stored contents are
// never cleared; dout reads 0 while empty.
module tap_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    limit;
    logic             do_push, do_pop;

    assign limit   = single ? CW'(1) : CAP;
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q >= limit);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;
    assign dout    = empty ? '0 : mem[rd_q];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= din;
        end
    end

    // Advance pointers and occupancy; reset or flush returns them to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == LAST) ? '0 : wr_q + AW'(1);
            end
            if (do_pop) begin
                rd_q <= (rd_q == LAST) ? '0 : rd_q + AW'(1);
            end
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/tap_regs.sv
// Control registers: test-access bit, queue-enable bit and the flush pulse.
// Assumes: the flush pulse is registered, so it acts one cycle after the
// write that changes the test-access bit. Build parameters remove features.
module tap_regs
    import uart_tap_pkg::*;
#(
    parameter bit ACC_EN       = 1'b1,
    parameter bit FIFO_PRESENT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic       wbit,
    output logic       test_mode,
    output logic       fifo_en,
    output logic       flush
);
    generate
        if (ACC_EN) begin : g_acc
            logic mode_q, flush_q, mode_wr;
            assign mode_wr = wr_en && (addr == OFS_TACC);
            // Hold the test-access bit and raise a flush when its value changes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mode_q  <= 1'b0;
                    flush_q <= 1'b0;
                end else begin
                    flush_q <= mode_wr && (wbit != mode_q);
                    if (mode_wr) begin
                        mode_q <= wbit;
                    end
                end
            end
            assign test_mode = mode_q;
            assign flush     = flush_q;
        end else begin : g_noacc
            assign test_mode = 1'b0;
            assign flush     = 1'b0;
        end

        if (FIFO_PRESENT) begin : g_fen
            logic fen_q;
            // Hold the run-time queue-enable bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fen_q <= 1'b0;
                end else if (wr_en && (addr == OFS_CTRL)) begin
                    fen_q <= wbit;
                end
            end
            assign fifo_en = fen_q;
        end else begin : g_nofen
            assign fifo_en = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/tap_route.sv
// Steers host and serial strobes to the two queues according to the mode.
// Assumes host strobes are already decoded to the data-register offset.
module tap_route #(
    parameter int WIDTH = 8
) (
    input  logic             test_mode,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [WIDTH-1:0] host_din,
    input  logic             ser_push,
    input  logic [WIDTH-1:0] ser_din,
    input  logic             ser_pop,
    output logic             rx_push,
    output logic             rx_pop,
    output logic [WIDTH-1:0] rx_din,
    output logic             tx_push,
    output logic             tx_pop,
    output logic [WIDTH-1:0] tx_din
);
    // Pick the producer and consumer of each queue.
    always_comb begin
        tx_din = host_din;
        if (test_mode) begin
            rx_push = host_wr;
            rx_din  = host_din;
            rx_pop  = 1'b0;
            tx_push = 1'b0;
            tx_pop  = host_rd;
        end else begin
            rx_push = ser_push;
            rx_din  = ser_din;
            rx_pop  = host_rd;
            tx_push = host_wr;
            tx_pop  = ser_pop;
        end
    end
endmodule

// File: rtl/uart_tap_ctrl.sv
// Top: UART receive/transmit queue pair with a host test-access mode.
// Assumes WIDTH <= 32; register reads are combinational from reg_addr and a
// read strobe on the data register pops the queue the mode selects.
module uart_tap_ctrl
    import uart_tap_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int WIDTH        = 8,
    parameter bit ACC_EN       = 1'b1,
    parameter bit FIFO_PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             ser_rx_push,
    input  logic [WIDTH-1:0] ser_rx_data,
    input  logic             ser_tx_pop,
    output logic [WIDTH-1:0] ser_tx_data,
    output logic             ser_tx_valid
);
    logic             test_mode, fifo_en, flush;
    logic             host_wr, host_rd;
    logic             rx_push, rx_pop, tx_push, tx_pop;
    logic [WIDTH-1:0] rx_din, tx_din, rx_dout, tx_dout;
    logic             rx_empty, rx_full, tx_empty, tx_full;
    tap_status_t      stat;

    assign host_wr = reg_wr_en && (reg_addr == OFS_DATA);
    assign host_rd = reg_rd_en && (reg_addr == OFS_DATA);

    generate
        if (WIDTH < 32) begin : g_pad
            logic wdata_unused;
            assign wdata_unused = ^reg_wdata[31:WIDTH];
        end
    endgenerate

    tap_regs #(.ACC_EN(ACC_EN), .FIFO_PRESENT(FIFO_PRESENT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wbit(reg_wdata[0]), .test_mode(test_mode), .fifo_en(fifo_en),
        .flush(flush)
    );

    tap_route #(.WIDTH(WIDTH)) u_route (
        .test_mode(test_mode), .host_wr(host_wr), .host_rd(host_rd),
        .host_din(reg_wdata[WIDTH-1:0]), .ser_push(ser_rx_push),
        .ser_din(ser_rx_data), .ser_pop(ser_tx_pop),
        .rx_push(rx_push), .rx_pop(rx_pop), .rx_din(rx_din),
        .tx_push(tx_push), .tx_pop(tx_pop), .tx_din(tx_din)
    );

    tap_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(~fifo_en),
        .push(rx_push), .pop(rx_pop), .din(rx_din), .dout(rx_dout),
        .empty(rx_empty), .full(rx_full)
    );

    tap_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(~fifo_en),
        .push(tx_push), .pop(tx_pop), .din(tx_din), .dout(tx_dout),
        .empty(tx_empty), .full(tx_full)
    );

    assign stat         = '{tx_full: tx_full, tx_empty: tx_empty,
                            rx_full: rx_full, rx_empty: rx_empty};
    assign ser_tx_data  = tx_dout;
    assign ser_tx_valid = ~tx_empty;

    // Register read multiplexer; unmapped offsets and reserved bits read 0.
    always_comb begin
        case (reg_addr)
            OFS_DATA: reg_rdata = 32'(test_mode ? tx_dout : rx_dout);
            OFS_CTRL: reg_rdata = {31'b0, fifo_en};
            OFS_STAT: reg_rdata = {28'b0, stat};
            OFS_TACC: reg_rdata = {31'b0, test_mode};
            default:  reg_rdata = 32'b0;
        endcase
    end
endmodule

// File: rtl/uart_tap_ctrl_chk.sv
// Checker for uart_tap_ctrl: timing of the flush, mode stability, serial
// isolation in test mode and zero data on an empty transmit queue.
module uart_tap_ctrl_chk
    import uart_tap_pkg::*;
#(
    parameter bit ACC_EN = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic        reg_rd_en,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        test_mode,
    input logic        flush,
    input logic        rx_empty,
    input logic        rx_full,
    input logic        tx_empty,
    input logic        ser_rx_push,
    input logic        ser_tx_pop,
    input logic        ser_tx_valid,
    input logic [7:0]  ser_tx_data
);
    logic data_acc, tacc_wr;
    assign data_acc = (reg_wr_en || reg_rd_en) && (reg_addr == OFS_DATA);
    assign tacc_wr  = reg_wr_en && (reg_addr == OFS_TACC);

    // R7: a changing mode write empties both queues two edges later.
    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ACC_EN && tacc_wr && (reg_wdata[0] != test_mode)) |=> ##1 (rx_empty && tx_empty));

    // R7: rewriting the held value raises no flush.
    p_same_value_no_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tacc_wr && (reg_wdata[0] == test_mode)) |=> !flush);

    // R2: only a write to the test-access offset moves the mode bit.
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tacc_wr |=> $stable(test_mode));

    // R3: with the feature removed the mode never leaves normal.
    p_noacc_normal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ACC_EN |-> !test_mode);

    // R8: serial strobes alone move no queue in test mode.
    p_serial_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !flush && !data_acc && (ser_rx_push || ser_tx_pop))
        |=> ($stable(rx_empty) && $stable(rx_full) && $stable(tx_empty)));

    // R9: an empty transmit queue presents zero.
    p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_tx_valid |-> (ser_tx_data == 8'h00));
endmodule

bind uart_tap_ctrl uart_tap_ctrl_chk #(.ACC_EN(ACC_EN)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .test_mode(test_mode),
    .flush(flush), .rx_empty(rx_empty), .rx_full(rx_full),
    .tx_empty(tx_empty), .ser_rx_push(ser_rx_push), .ser_tx_pop(ser_tx_pop),
    .ser_tx_valid(ser_tx_valid), .ser_tx_data(8'(ser_tx_data))
);

// File: tb/uart_tap_ctrl_test.sv
`timescale 1ns/1ps
module uart_tap_ctrl_test;
    localparam int DEPTH = 16;
    localparam logic [7:0] A_DATA = 8'h00, A_CTRL = 8'h08, A_STAT = 8'h14, A_TACC = 8'h70;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        reg_wr_en = 0, reg_rd_en = 0, ser_rx_push = 0, ser_tx_pop = 0;
    logic [7:0]  reg_addr = A_STAT, ser_rx_data = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [7:0]  ser_tx_data;
    logic        ser_tx_valid;

    logic        n_wr = 0, n_rd = 0, n_push = 0, n_pop = 0;
    logic [7:0]  n_addr = A_STAT, n_pdata = 0, n_txd;
    logic [31:0] n_wdata = 0, n_rdata;
    logic        n_txv;

    uart_tap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data), .ser_tx_valid(ser_tx_valid)
    );

    uart_tap_ctrl #(.ACC_EN(1'b0), .FIFO_PRESENT(1'b0)) uut_noacc (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(n_wr), .reg_rd_en(n_rd),
        .reg_addr(n_addr), .reg_wdata(n_wdata), .reg_rdata(n_rdata),
        .ser_rx_push(n_push), .ser_rx_data(n_pdata),
        .ser_tx_pop(n_pop), .ser_tx_data(n_txd), .ser_tx_valid(n_txv)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model of the main instance.
    logic [7:0] rxq[$], txq[$];
    bit m_mode = 0, m_fen = 0, m_fpend = 0;
    int lim;
    bit hw, hr;

    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_mode = 0; m_fen = 0; m_fpend = 0;
        end else begin
            lim = m_fen ? DEPTH : 1;
            hw  = reg_wr_en && reg_addr == A_DATA;
            hr  = reg_rd_en && reg_addr == A_DATA;
            if (m_fpend) begin
                rxq.delete(); txq.delete();
            end else if (m_mode) begin
                if (hw && rxq.size() < lim) rxq.push_back(reg_wdata[7:0]);
                if (hr && txq.size() > 0) void'(txq.pop_front());
            end else begin
                if (hw && txq.size() < lim) txq.push_back(reg_wdata[7:0]);
                if (hr && rxq.size() > 0) void'(rxq.pop_front());
                if (ser_rx_push && rxq.size() < lim) rxq.push_back(ser_rx_data);
                if (ser_tx_pop && txq.size() > 0) void'(txq.pop_front());
            end
            m_fpend = reg_wr_en && reg_addr == A_TACC && reg_wdata[0] != m_mode;
            if (reg_wr_en && reg_addr == A_TACC) m_mode = reg_wdata[0];
            if (reg_wr_en && reg_addr == A_CTRL) m_fen = reg_wdata[0];
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int l;
        l = m_fen ? DEPTH : 1;
        case (a)
            A_DATA: return m_mode ? ((txq.size() > 0) ? 32'(txq[0]) : 0)
                                  : ((rxq.size() > 0) ? 32'(rxq[0]) : 0);
            A_CTRL: return {31'b0, m_fen};
            A_STAT: return {28'b0, txq.size() >= l, txq.size() == 0,
                            rxq.size() >= l, rxq.size() == 0};
            A_TACC: return {31'b0, m_mode};
            default: return 0;
        endcase
    endfunction

    // Per-cycle comparison against the model (R4, R10 at the ports).
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(reg_rdata == m_read(reg_addr), "R10 per-cycle rdata", reg_rdata, m_read(reg_addr));
            chk(ser_tx_valid == (txq.size() != 0), "R4 per-cycle tx_valid", 32'(ser_tx_valid), 32'(txq.size() != 0));
            chk(ser_tx_data == ((txq.size() > 0) ? txq[0] : 8'h00), "R4 per-cycle tx_data",
                32'(ser_tx_data), (txq.size() > 0) ? 32'(txq[0]) : 0);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 0; reg_addr = A_STAT;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); reg_rd_en = 1; reg_addr = a;
        #1 chk(reg_rdata == e, tag, reg_rdata, e);
        @(negedge clk); reg_rd_en = 0; reg_addr = A_STAT;
    endtask

    task automatic spush(input logic [7:0] d);
        @(negedge clk); ser_rx_push = 1; ser_rx_data = d;
        @(negedge clk); ser_rx_push = 0;
    endtask

    task automatic spop();
        @(negedge clk); ser_tx_pop = 1;
        @(negedge clk); ser_tx_pop = 0;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_exp(A_TACC, 0, "R1 mode");
        rd_exp(A_CTRL, 0, "R1 fen");
        rd_exp(A_STAT, 32'h5, "R1 status");
        chk(ser_tx_valid == 0, "R1 tx_valid", 32'(ser_tx_valid), 0);
        // R2 reserved bits and bit 0
        wr(A_TACC, 32'hFFFF_FFFE);
        rd_exp(A_TACC, 0, "R2 bit0 clear");
        wr(A_TACC, 32'hFFFF_FFFF);
        rd_exp(A_TACC, 1, "R2 reserved read zero");
        wr(A_TACC, 0);
        rd_exp(A_TACC, 0, "R2 back to normal");
        // R6 enable queues
        wr(A_CTRL, 1);
        rd_exp(A_CTRL, 1, "R6 fen set");
        // R4 normal receive path
        spush(8'hA1); spush(8'hB2); spush(8'hC3);
        rd_exp(A_DATA, 32'hA1, "R4 rx order 0");
        rd_exp(A_DATA, 32'hB2, "R4 rx order 1");
        rd_exp(A_DATA, 32'hC3, "R4 rx order 2");
        rd_exp(A_DATA, 0, "R9 empty read zero");
        rd_exp(A_STAT, 32'h5, "R9 empty pop no move");
        spush(8'h44);
        rd_exp(A_DATA, 32'h44, "R9 pointers intact");
        // R4 normal transmit path
        wr(A_DATA, 32'h11); wr(A_DATA, 32'h22);
        chk(ser_tx_data == 8'h11, "R4 tx head", 32'(ser_tx_data), 32'h11);
        spop();
        chk(ser_tx_data == 8'h22, "R4 tx second", 32'(ser_tx_data), 32'h22);
        spop();
        chk(ser_tx_valid == 0, "R4 tx drained", 32'(ser_tx_valid), 0);
        spop();
        chk(ser_tx_data == 0, "R9 tx empty pop", 32'(ser_tx_data), 0);
        // R9 full receive queue drops extra
        for (int i = 0; i < DEPTH; i++) spush(8'(i + 1));
        rd_exp(A_STAT, 32'h6, "R10 rx full flags");
        spush(8'hEE);
        for (int i = 0; i < DEPTH; i++) rd_exp(A_DATA, 32'(i + 1), "R9 full drop order");
        rd_exp(A_DATA, 0, "R9 drained");
        // R7 flush timing
        spush(8'h55); wr(A_DATA, 32'h66);
        wr(A_TACC, 1);
        chk(ser_tx_valid == 1, "R7 contents held one cycle", 32'(ser_tx_valid), 1);
        @(negedge clk); #1;
        chk(ser_tx_valid == 0, "R7 flushed", 32'(ser_tx_valid), 0);
        rd_exp(A_STAT, 32'h5, "R7 both empty");
        // R5 test-access with queues
        wr(A_DATA, 32'h77); wr(A_DATA, 32'h88);
        rd_exp(A_STAT, 32'h4, "R5 host write fills rx");
        rd_exp(A_DATA, 0, "R5 host read takes tx");
        for (int i = 0; i < DEPTH - 2; i++) wr(A_DATA, 32'(i));
        rd_exp(A_STAT, 32'h6, "R5 rx full via host");
        // R8 and R6 single-entry in test mode
        wr(A_CTRL, 0);
        wr(A_TACC, 0); wr(A_TACC, 1);
        repeat (2) @(negedge clk);
        spush(8'h99);
        rd_exp(A_STAT, 32'h5, "R8 serial push ignored");
        wr(A_DATA, 32'h12);
        rd_exp(A_STAT, 32'h6, "R6 single entry full");
        wr(A_DATA, 32'h34);
        rd_exp(A_STAT, 32'h6, "R6 second write dropped");
        // R7 same-value write keeps contents
        wr(A_TACC, 1);
        repeat (2) @(negedge clk);
        rd_exp(A_STAT, 32'h6, "R7 no flush on same value");
        wr(A_TACC, 0);
        repeat (2) @(negedge clk);
        rd_exp(A_STAT, 32'h5, "R7 flush on return");
        // R6 single entry in normal mode
        spush(8'h5A); spush(8'h5B);
        rd_exp(A_DATA, 32'h5A, "R6 holding entry");
        rd_exp(A_DATA, 0, "R6 second push dropped");
        // R3 and R11 on the reduced instance
        @(negedge clk); n_wr = 1; n_addr = A_TACC; n_wdata = 32'h1;
        @(negedge clk); n_wr = 0; n_addr = A_TACC;
        #1 chk(n_rdata == 0, "R3 write ignored", n_rdata, 0);
        @(negedge clk); n_wr = 1; n_addr = A_CTRL; n_wdata = 32'h1;
        @(negedge clk); n_wr = 0;
        #1 chk(n_rdata == 0, "R11 fen stuck 0", n_rdata, 0);
        @(negedge clk); n_push = 1; n_pdata = 8'h3C;
        @(negedge clk); n_push = 0; n_addr = A_DATA;
        #1 chk(n_rdata == 32'h3C, "R3 normal path", n_rdata, 32'h3C);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule